// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is one channel of a direct memory access engine. Software programs a source address, a destination address, a unit count and a control word through 16-bit register writes. When the control word's enable bit goes from 0 to 1, the channel copies the programmed source, destination and count into working registers. A block then runs, either at once or when a start pulse arrives, depending on the start-timing field. Each unit of a block is a read from the source followed by a write of the same data to the destination. A unit is a halfword or a word. The source and destination addresses each move by their own adjustment mode.

When a block ends, the channel can pulse an interrupt. In repeat mode it stays armed for the next start pulse and can restore the destination address. Otherwise it clears its own enable bit. An audio FIFO feed mode sends four words per trigger to a fixed FIFO address, whatever the programmed count and size. Choosing between channels and producing start pulses are left to the surrounding logic.

Top module: `dmach_top`

## Requirements
- R1: After reset, `busy`, `mem_req` and `irq` are low.
- R2: Register writes use offset 0 for source bits 15:0, 1 for source bits 27:16, 2 for destination bits 15:0, 3 for destination bits 27:16, 4 for the count and 5 for control. A write to offset 1 or 3 keeps only `reg_wdata[11:0]`.
- R3: The working source, destination and count are copied one cycle after the control write that raises enable. Writes to the address registers after that copy do not change the addresses the next block uses.
- R4: A count of 0 means 0x4000 units when `CH_ID` is 0 to 2, and 0x10000 units when `CH_ID` is 3.
- R5: Control bits 8:7 select the source mode: 0 increments, 1 decrements, 2 holds and 3 also holds. Every unit reads the source and then writes the data it read to the destination. A halfword write carries the read's low 16 bits in `mem_wdata[15:0]`, with the upper bits zero.
- R6: Control bits 6:5 select the destination mode: 0 increments, 1 decrements, 2 holds and 3 increments. Control bit 10 set means 32-bit units with a step of 4 bytes. Bit 10 clear means 16-bit units with a step of 2 bytes, and `mem_size` shows bit 10.
- R7: `mem_addr` has its low two bits cleared for word units and its low bit cleared for halfword units. The unaligned working address still moves by the full step.
- R8: The first read of a block has `mem_seq` low and every later access in the block has it high. A request that is not acknowledged keeps its address until it is acknowledged or dropped.
- R9: FIFO feed mode is chosen at enable time when timing (bits 13:12) is 3, repeat (bit 9) is set, `CH_ID` is 1 or 2, and the destination equals `FIFO_A` or `FIFO_B`. Each trigger then moves four words. The source increments by 4 across triggers and the destination stays fixed.
- R10: When bit 14 is set, `irq` is high for exactly the one cycle in which the block's last write is acknowledged. When bit 14 is clear, `irq` stays low.
- R11: With repeat set, enable stays set after a block and each start pulse runs another block. The source continues from where the last block stopped. The destination goes back to the programmed value only with destination mode 3.
- R12: Without repeat, enable clears at block end, and later start pulses start nothing.
- R13: Writing control with enable clear during a block drops `mem_req` at once. `busy` falls one cycle later, and no interrupt follows.
- R14: Timing 0 starts the block in the cycle after the enabling write. Any other timing waits for a `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ofs | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| start | input | 1 | Trigger pulse for a block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Aligned byte address |
| mem_size | output | 1 | 1 for word, 0 for halfword |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Completes the current request |
| mem_seq | output | 1 | Sequential access marker |
| irq | output | 1 | Block completion pulse |
| busy | output | 1 | A block is in progress |

## Verification
The bench builds the channel with `CH_ID` set to 1 and the default 28-bit addresses and 16-bit count. Channel 1 makes FIFO feed mode reachable, and a zero count becomes a 0x4000-unit block that runs to completion within the bench's budget. The FIFO addresses keep their defaults, so one of them can be programmed as the destination. Acknowledge delays are random, so requests are held over several cycles, and a block is aborted in the middle of a transfer.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    ADJ_INC     = 2'd0,
    ADJ_DEC     = 2'd1,
    ADJ_FIX     = 2'd2,
    ADJ_INC_RLD = 2'd3
  } adj_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;

  // Control field positions that software relies on
  localparam int CF_DADJ = 5;
  localparam int CF_SADJ = 7;
  localparam int CF_RPT  = 9;
  localparam int CF_WORD = 10;
  localparam int CF_TIM  = 12;
  localparam int CF_IE   = 14;
  localparam int CF_EN   = 15;

  localparam logic [2:0] OFS_SRC_LO = 3'd0;
  localparam logic [2:0] OFS_SRC_HI = 3'd1;
  localparam logic [2:0] OFS_DST_LO = 3'd2;
  localparam logic [2:0] OFS_DST_HI = 3'd3;
  localparam logic [2:0] OFS_CNT    = 3'd4;
  localparam logic [2:0] OFS_CTL    = 3'd5;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic [1:0] timing;
    logic       word;
    logic       rpt;
    logic [1:0] sadj;
    logic [1:0] dadj;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [15:0] w);
    ctl_t c;
    c.en     = w[CF_EN];
    c.ie     = w[CF_IE];
    c.timing = w[CF_TIM+1:CF_TIM];
    c.word   = w[CF_WORD];
    c.rpt    = w[CF_RPT];
    c.sadj   = w[CF_SADJ+1:CF_SADJ];
    c.dadj   = w[CF_DADJ+1:CF_DADJ];
    return c;
  endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        ofs,
  input  logic [15:0]       wdata,
  input  logic              clr_en,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output ctl_t              ctl_q
);
  localparam int HI_W = ADDR_W - 16;

  logic [ADDR_W-1:0] src_d, dst_d;
  logic [CNT_W-1:0]  cnt_d;
  ctl_t              ctl_d;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    ctl_d = ctl_q;
    if (clr_en) ctl_d.en = 1'b0;
    if (wr) begin
      unique case (ofs)
        OFS_SRC_LO: src_d[15:0]        = wdata;
        OFS_SRC_HI: src_d[ADDR_W-1:16] = wdata[HI_W-1:0];
        OFS_DST_LO: dst_d[15:0]        = wdata;
        OFS_DST_HI: dst_d[ADDR_W-1:16] = wdata[HI_W-1:0];
        OFS_CNT:    cnt_d              = wdata[CNT_W-1:0];
        OFS_CTL:    ctl_d              = ctl_decode(wdata);
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/dmach_step.sv
module dmach_step
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic [ADDR_W-1:0] addr,
  input  adj_e              mode,
  input  logic              word,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] stride;

  always_comb begin
    stride = word ? ADDR_W'(4) : ADDR_W'(2);
    unique case (mode)
      ADJ_INC, ADJ_INC_RLD: nxt = addr + stride;
      ADJ_DEC:              nxt = addr - stride;
      default:              nxt = addr;
    endcase
  end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int              ADDR_W = 28,
  parameter int              CNT_W  = 16,
  parameter int              CH_ID  = 0,
  parameter logic [ADDR_W-1:0] FIFO_A = 'h0A0,
  parameter logic [ADDR_W-1:0] FIFO_B = 'h0A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              start,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic [31:0]       mem_wdata,
  output logic              mem_seq,
  output logic              irq,
  output logic              busy,
  output logic              clr_en
);
  localparam int BLK_W = CNT_W + 1;
  localparam logic [BLK_W-1:0] ZERO_LEN = (CH_ID == 3) ? BLK_W'(1) << CNT_W
                                                       : BLK_W'(1) << (CNT_W - 2);
  localparam logic [BLK_W-1:0] FIFO_LEN = BLK_W'(4);

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] wsrc_q, wsrc_d, wdst_q, wdst_d;
  logic [BLK_W-1:0]  left_q, left_d, blk_q, blk_d;
  logic              fifo_q, fifo_d, first_q, first_d, enp_q;
  logic [31:0]       data_q, data_d;

  logic              rise, wrd, last, fifo_hit;
  logic [BLK_W-1:0]  cnt_len, new_len;
  logic [ADDR_W-1:0] src_nx, dst_nx;
  adj_e              smode, dmode;

  // FIFO feed mode exists only on the channels that serve the audio FIFOs
  generate
    if (CH_ID == 1 || CH_ID == 2) begin : g_fifo
      assign fifo_hit = (ctl.timing == 2'd3) && ctl.rpt &&
                        ((dst_q == FIFO_A) || (dst_q == FIFO_B));
    end else begin : g_nofifo
      assign fifo_hit = 1'b0;
    end
  endgenerate

  assign rise    = ctl.en & ~enp_q;
  assign wrd     = fifo_q | ctl.word;
  assign last    = (left_q == BLK_W'(1));
  assign cnt_len = (cnt_q == '0) ? ZERO_LEN : {1'b0, cnt_q};
  assign new_len = fifo_hit ? FIFO_LEN : cnt_len;

  always_comb begin
    if (fifo_q)                     smode = ADJ_INC;
    else if (ctl.sadj == 2'd3)      smode = ADJ_FIX;
    else                            smode = adj_e'(ctl.sadj);
    dmode = fifo_q ? ADJ_FIX : adj_e'(ctl.dadj);
  end

  dmach_step #(.ADDR_W(ADDR_W)) u_src_step (
    .addr(wsrc_q), .mode(smode), .word(wrd), .nxt(src_nx));
  dmach_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .addr(wdst_q), .mode(dmode), .word(wrd), .nxt(dst_nx));

  always_comb begin
    st_d    = st_q;
    wsrc_d  = wsrc_q;
    wdst_d  = wdst_q;
    left_d  = left_q;
    blk_d   = blk_q;
    fifo_d  = fifo_q;
    first_d = first_q;
    data_d  = data_q;
    clr_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rise) begin
          wsrc_d = src_q;
          wdst_d = dst_q;
          fifo_d = fifo_hit;
          blk_d  = new_len;
          if (ctl.timing == 2'd0) begin
            st_d    = ST_RD;
            left_d  = new_len;
            first_d = 1'b1;
          end
        end else if (start && ctl.en) begin
          st_d    = ST_RD;
          left_d  = blk_q;
          first_d = 1'b1;
        end
      end
      ST_RD: begin
        if (!ctl.en) begin
          st_d = ST_IDLE;
        end else if (mem_ack) begin
          data_d = wrd ? mem_rdata : {16'h0000, mem_rdata[15:0]};
          st_d   = ST_WR;
        end
      end
      ST_WR: begin
        if (!ctl.en) begin
          st_d = ST_IDLE;
        end else if (mem_ack) begin
          wsrc_d  = src_nx;
          wdst_d  = dst_nx;
          left_d  = left_q - BLK_W'(1);
          first_d = 1'b0;
          if (last) begin
            st_d = ST_IDLE;
            if (ctl.rpt) begin
              if (ctl.dadj == 2'd3 && !fifo_q) wdst_d = dst_q;
            end else begin
              clr_en = 1'b1;
            end
          end else begin
            st_d = ST_RD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wsrc_q  <= '0;
      wdst_q  <= '0;
      left_q  <= '0;
      blk_q   <= '0;
      fifo_q  <= 1'b0;
      first_q <= 1'b0;
      data_q  <= '0;
      enp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      wsrc_q  <= wsrc_d;
      wdst_q  <= wdst_d;
      left_q  <= left_d;
      blk_q   <= blk_d;
      fifo_q  <= fifo_d;
      first_q <= first_d;
      data_q  <= data_d;
      enp_q   <= ctl.en;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = busy & ctl.en;
  assign mem_we    = (st_q == ST_WR);
  assign mem_size  = wrd;
  assign mem_seq   = ~((st_q == ST_RD) & first_q);
  assign mem_wdata = data_q;
  assign irq       = (st_q == ST_WR) & ctl.en & mem_ack & last & ctl.ie;

  always_comb begin
    mem_addr = (st_q == ST_WR) ? wdst_q : wsrc_q;
    mem_addr[0] = 1'b0;
    if (wrd) mem_addr[1] = 1'b0;
  end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int                ADDR_W = 28,
  parameter int                CNT_W  = 16,
  parameter int                CH_ID  = 0,
  parameter logic [ADDR_W-1:0] FIFO_A = 'h0A0,
  parameter logic [ADDR_W-1:0] FIFO_B = 'h0A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_ofs,
  input  logic [15:0]       reg_wdata,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              mem_seq,
  output logic              irq,
  output logic              busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  ctl_t              ctl_q;
  logic              clr_en;

  // Asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .ofs(reg_ofs),
    .wdata(reg_wdata), .clr_en(clr_en), .src_q(src_q), .dst_q(dst_q),
    .cnt_q(cnt_q), .ctl_q(ctl_q));

  dmach_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_ID(CH_ID),
              .FIFO_A(FIFO_A), .FIFO_B(FIFO_B)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .ctl(ctl_q), .src_q(src_q),
    .dst_q(dst_q), .cnt_q(cnt_q), .start(start), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_seq(mem_seq), .irq(irq), .busy(busy), .clr_en(clr_en));
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_size,
  input logic              mem_seq,
  input logic              mem_ack,
  input logic              irq,
  input logic              busy
);
  assert_word_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));

  assert_half_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  assert_write_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_seq);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));

  assert_irq_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mem_req && mem_we && mem_ack));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_req_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

bind dmach_top dmach_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_seq(mem_seq),
  .mem_ack(mem_ack), .irq(irq), .busy(busy));

// File: tb/dmach_top_tb_top.sv
`timescale 1ns/1ps
module dmach_top_tb_top;
  localparam logic [27:0] FA = 28'h00000A0;
  localparam logic [27:0] FB = 28'h00000A4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_ofs;
  logic [15:0] reg_wdata;
  logic        start;
  logic        mem_req, mem_we, mem_size, mem_seq, irq, busy;
  logic [27:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int vectors = 0;
  int miss = 0;
  bit finished = 0;

  // model of the running block
  logic [27:0] m_src, m_dst, p_dst, first_addr;
  logic [31:0] m_data;
  logic [1:0]  m_smode, m_dmode;
  logic        m_word, m_ie, m_first, p_reload;
  int          m_len, m_left;
  int          acc_n, acc_bad, irq_n;

  always #2 clk = ~clk;

  dmach_top #(.ADDR_W(28), .CNT_W(16), .CH_ID(1), .FIFO_A(FA), .FIFO_B(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .reg_wdata(reg_wdata), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_seq(mem_seq),
    .irq(irq), .busy(busy));

  function automatic logic [27:0] al(input logic [27:0] a, input logic w);
    return w ? {a[27:2], 2'b00} : {a[27:1], 1'b0};
  endfunction

  function automatic logic [27:0] stp(input logic [27:0] a, input logic [1:0] m, input logic w);
    logic [27:0] s;
    s = w ? 28'd4 : 28'd2;
    if (m == 2'd0)      return a + s;
    else if (m == 2'd1) return a - s;
    else                return a;
  endfunction

  function automatic logic [15:0] mk_ctl(input logic en, input logic ie, input logic [1:0] tim,
                                         input logic w, input logic rpt,
                                         input logic [1:0] sa, input logic [1:0] da);
    return {en, ie, tim, 1'b0, w, rpt, sa, da, 5'b00000};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  // memory responder and access monitor
  always begin
    @(negedge clk);
    mem_ack = rst_n && mem_req && (($urandom % 4) != 0);
    mem_rdata = {mem_addr[15:0] ^ 16'h3C5A, mem_addr[27:12]};
    #1;
    if (irq) irq_n++;
    if (mem_req && mem_ack) begin
      acc_n++;
      if (!mem_we) begin
        if (acc_n == 1) first_addr = mem_addr;
        if (mem_addr !== al(m_src, m_word) || mem_seq !== !m_first || mem_size !== m_word)
          acc_bad++;
        m_data = m_word ? mem_rdata : {16'h0000, mem_rdata[15:0]};
        m_first = 0;
      end else begin
        if (mem_addr !== al(m_dst, m_word) || mem_wdata !== m_data || mem_seq !== 1'b1 ||
            mem_size !== m_word || irq !== (m_ie && m_left == 1))
          acc_bad++;
        m_src = stp(m_src, m_smode, m_word);
        m_dst = stp(m_dst, m_dmode, m_word);
        m_left--;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] o, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_ofs = o; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic begin_blk();
    m_left = m_len; m_first = 1; acc_n = 0; acc_bad = 0; irq_n = 0;
  endtask

  task automatic prog(input logic [27:0] s, input logic [27:0] d, input logic [15:0] c,
                      input logic [15:0] ctl);
    logic fifo;
    wr_reg(3'd5, 16'h0000);
    wr_reg(3'd0, s[15:0]);
    wr_reg(3'd1, {4'hF, s[27:16]});
    wr_reg(3'd2, d[15:0]);
    wr_reg(3'd3, {4'hA, d[27:16]});
    wr_reg(3'd4, c);
    fifo = (ctl[13:12] == 2'd3) && ctl[9] && (d == FA || d == FB);
    m_word   = fifo | ctl[10];
    m_len    = fifo ? 4 : ((c == 0) ? 16384 : int'(c));
    m_ie     = ctl[14];
    m_smode  = fifo ? 2'd0 : ((ctl[8:7] == 2'd3) ? 2'd2 : ctl[8:7]);
    m_dmode  = fifo ? 2'd2 : ((ctl[6:5] == 2'd3) ? 2'd0 : ctl[6:5]);
    m_src    = s;
    m_dst    = d;
    p_dst    = d;
    p_reload = (ctl[6:5] == 2'd3) && !fifo;
    begin_blk();
    wr_reg(3'd5, ctl);
  endtask

  task automatic fire();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic end_blk(input string req, input int n, input int nirq);
    check({req, " accesses match model"}, 64'(acc_bad), 64'd0);
    check({req, " access count"}, 64'(acc_n), 64'(n));
    check({req, " irq pulses"}, 64'(irq_n), 64'(nirq));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miss++; vectors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [27:0] s, d;
    void'($urandom(32'h5EED_0123));
    rst_n = 0; reg_wr = 0; reg_ofs = 0; reg_wdata = 0; start = 0;
    m_len = 1; m_word = 0; m_ie = 0; m_smode = 0; m_dmode = 0;
    m_src = 0; m_dst = 0; p_dst = 0; p_reload = 0; m_data = 0;
    first_addr = 0;
    begin_blk();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    check("R1 irq", 64'(irq), 0);

    // R2 upper address half keeps 12 bits; halfword inc/inc, timing 0 (R14)
    prog(28'hABC1236, 28'h0020002, 16'd3, mk_ctl(1, 1, 2'd0, 0, 0, 2'd0, 2'd0));
    wait_idle();
    check("R2 first address", 64'(first_addr), 64'(28'hABC1236));
    end_blk("R5 R6 R8 R10 R14", 6, 1);
    // R12 enable cleared, start ignored
    fire();
    check("R12 busy after start", 64'(busy), 0);
    check("R12 req after start", 64'(mem_req), 0);

    // R3 latch point, R11 repeat with destination reload, R14 wait for start
    s = 28'h0301002; d = 28'h0400010;
    prog(s, d, 16'd3, mk_ctl(1, 1, 2'd1, 1, 1, 2'd0, 2'd3));
    repeat (2) @(negedge clk);
    check("R14 no start without pulse", 64'(busy), 0);
    wr_reg(3'd0, 16'h7770);
    wr_reg(3'd1, 16'h0555);
    begin_blk();
    fire();
    wait_idle();
    check("R3 latched source used", 64'(first_addr), 64'(al(s, 1)));
    end_blk("R3 R7", 6, 1);
    begin_blk();
    if (p_reload) m_dst = p_dst;
    fire();
    wait_idle();
    check("R11 source continues", 64'(first_addr), 64'(al(s + 28'd12, 1)));
    end_blk("R11", 6, 1);
    wr_reg(3'd5, 16'h0000);

    // R9 FIFO feed: halfword bit clear, count 7, dec source code ignored
    s = 28'h0200040;
    prog(s, FB, 16'd7, mk_ctl(1, 0, 2'd3, 0, 1, 2'd1, 2'd0));
    @(negedge clk);
    check("R9 waits for trigger", 64'(busy), 0);
    begin_blk(); fire(); wait_idle();
    end_blk("R9 first trigger", 8, 0);
    begin_blk(); fire(); wait_idle();
    end_blk("R9 second trigger", 8, 0);
    check("R9 source moved by 16", 64'(first_addr), 64'(s + 28'd16));
    wr_reg(3'd5, 16'h0000);

    // R13 abort mid-block
    prog(28'h0010000, 28'h0080000, 16'd200, mk_ctl(1, 1, 2'd0, 1, 0, 2'd2, 2'd1));
    repeat (30) @(negedge clk);
    wr_reg(3'd5, 16'h0000);
    check("R13 req dropped", 64'(mem_req), 0);
    @(negedge clk);
    check("R13 busy dropped", 64'(busy), 0);
    check("R13 accesses match model", 64'(acc_bad), 0);
    check("R13 no irq", 64'(irq_n), 0);

    // R4 zero count on channel 1 means 0x4000 units
    prog(28'h1000000, 28'h2000000, 16'd0, mk_ctl(1, 1, 2'd0, 0, 0, 2'd0, 2'd0));
    wait_idle();
    end_blk("R4", 2 * 16384, 1);

    // random blocks: R5 R6 R7 R10 across modes, sizes and alignment
    for (int i = 0; i < 10; i++) begin
      logic [15:0] c;
      logic ie, w;
      logic [1:0] sa, da;
      s  = 28'($urandom);
      d  = 28'($urandom);
      c  = 16'(1 + ($urandom % 12));
      ie = 1'($urandom);
      w  = 1'($urandom);
      sa = 2'($urandom);
      da = 2'($urandom);
      prog(s, d, c, mk_ctl(1, ie, 2'd0, w, 0, sa, da));
      wait_idle();
      end_blk("R5 R6 R7 R10 random", 2 * int'(c), int'(ie));
    end

    summary();
  end
endmodule